// File: doc/BRIEF.md
# Transport Stream PID Bitmap Filter

The block sits in the path of two independent byte-wide transport streams and decides, packet by packet, whether each 188-byte packet is passed on or thrown away. Each stream has its own bitmap with one bit for every one of the 8192 packet identifiers. A set bit removes packets carrying that identifier. A clear bit lets them through. The 32 lowest identifiers, which carry the stream's tables, are always forwarded, whatever is stored in the bitmap.

A host reaches the two bitmaps one byte at a time through a small register window. Two index registers select a byte and a stream. A data register reads or replaces the selected byte, so firmware can set or clear a single identifier with a read-modify-write.

Inside the block, each stream has a header parser. The parser collects the three header bytes, finds the identifier and looks it up in its own bitmap. A short queue holds the first bytes until that decision is known. The whole packet is then emitted with its start marker, or none of it is.

Top module: `ts_pid_filter`

## Requirements
- R1: Register 0x08 holds byte index bits 7:0. Register 0x09 holds byte index bits 9:8 in its bits 1:0, and the stream select in its bit 2 (0 = first stream, 1 = second stream). Reading 0x08 returns the value last written. Reading 0x09 returns the stored bits 2:0, with bits 7:3 read as zero.
- R2: A read of register 0x0A returns the addressed bitmap byte, and a write replaces it. Read data appears on `hostRdata` one cycle after the read strobe and holds until the next read. A read of any unused address returns zero.
- R3: After reset every bitmap bit is clear and no output is valid. Every well-formed packet is then forwarded.
- R4: The identifier is the 13-bit value {header byte 1 bits 4:0, header byte 2}, where header byte 0 is the byte marked by start. The bitmap bit for identifier P is bit P[2:0] of byte P[12:3]. A packet is dropped exactly when that bit is set.
- R5: Packets with identifier 0x00 to 0x1F are forwarded even when their bitmap bit is set.
- R6: Each stream is checked only against its own bitmap. A write to one stream's bitmap does not change the other stream's filtering or readback.
- R7: A forwarded packet appears on the output in its original order with no bytes lost, with the start marker on its first byte only. A dropped packet produces no output at all.
- R8: A packet whose first byte is not 0x47 is dropped.
- R9: A start that arrives before the third header byte ends the unfinished packet, and that packet is dropped. Bytes that arrive without start after a packet has reached its full length are discarded. A packet cut short by a start after its third byte keeps its decision and is emitted as far as it went.
- R10: The decision uses the bitmap as it stood before the cycle in which the third header byte is accepted. A host write in that cycle or later does not affect that packet. A write in an earlier cycle does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostSel | input | 1 | Host access strobe, one cycle per access |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 4 | Host register address |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, registered |
| inValid | input | NUM_STREAMS | Input byte valid, per stream |
| inStart | input | NUM_STREAMS | First byte of a packet, per stream |
| inData | input | NUM_STREAMS x 8 | Input byte, per stream |
| outValid | output | NUM_STREAMS | Output byte valid, per stream |
| outStart | output | NUM_STREAMS | First byte of a forwarded packet |
| outData | output | NUM_STREAMS x 8 | Output byte, per stream |

## Verification
The hardest case to reach from the ports is a host write that lands in exactly the same clock as a packet's third header byte, or one cycle before it. This boundary decides whether the new bitmap value or the old one governs that packet. The bench forks the packet driver and a host write that is delayed by a counted number of falling edges. This puts the write on header byte 1, byte 2 or byte 3 in turn. The bench then confirms on the output whether that packet and the one after it appear. Runt packets cut off before the decision, and stray bytes after a complete packet, are also driven on purpose. This checks that neither one leaks out or stalls the queue.

// File: rtl/ts_pidf_pkg.sv
package ts_pidf_pkg;
  localparam int PID_W      = 13;
  localparam int IDX_W      = PID_W - 3;
  localparam int LOW_BITS   = 5;
  localparam logic [7:0] SYNC_BYTE = 8'h47;
  localparam logic [3:0] REG_IDX_LO = 4'h8;
  localparam logic [3:0] REG_IDX_HI = 4'h9;
  localparam logic [3:0] REG_BYTE   = 4'hA;

  typedef struct packed {
    logic push;
    logic first;
    logic decPush;
    logic decPass;
  } rx_stb_t;

  typedef struct packed {
    logic wrIdxLo;
    logic wrIdxHi;
    logic wrByte;
    logic rdIdxLo;
    logic rdIdxHi;
    logic rdByte;
    logic rdOther;
  } host_stb_t;
endpackage

// File: rtl/ts_pidf_host_decode.sv
module ts_pidf_host_decode
  import ts_pidf_pkg::*;
(
  input  logic       hostSel,
  input  logic       hostWr,
  input  logic [3:0] hostAddr,
  output host_stb_t  stb
);
  always_comb begin
    stb = '0;
    if (hostSel) begin
      unique case (hostAddr)
        REG_IDX_LO: if (hostWr) stb.wrIdxLo = 1'b1; else stb.rdIdxLo = 1'b1;
        REG_IDX_HI: if (hostWr) stb.wrIdxHi = 1'b1; else stb.rdIdxHi = 1'b1;
        REG_BYTE:   if (hostWr) stb.wrByte  = 1'b1; else stb.rdByte  = 1'b1;
        default:    stb.rdOther = !hostWr;
      endcase
    end
  end
endmodule

// File: rtl/ts_pidf_bitmap_store.sv
module ts_pidf_bitmap_store
  import ts_pidf_pkg::*;
#(
  parameter int NUM_STREAMS = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  host_stb_t                         hostStb,
  input  logic [7:0]                        hostWdata,
  output logic [7:0]                        hostRdata,
  input  logic [NUM_STREAMS-1:0][IDX_W-1:0] lookIdx,
  output logic [NUM_STREAMS-1:0][7:0]       lookByte
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int HI_W  = IDX_W - 8;
  localparam int SEL_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;

  logic [7:0]       bitmap [NUM_STREAMS][DEPTH];
  logic [7:0]       idxLo;
  logic [HI_W-1:0]  idxHi;
  logic [SEL_W-1:0] selReg;
  logic [IDX_W-1:0] hostIdx;
  logic [7:0]       hiView;

  assign hostIdx = {idxHi, idxLo};
  assign hiView  = 8'({selReg, idxHi});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_STREAMS; s++)
        for (int i = 0; i < DEPTH; i++)
          bitmap[s][i] <= '0;
      idxLo     <= '0;
      idxHi     <= '0;
      selReg    <= '0;
      hostRdata <= '0;
    end else begin
      if (hostStb.wrIdxLo) idxLo <= hostWdata;
      if (hostStb.wrIdxHi) begin
        idxHi  <= hostWdata[HI_W-1:0];
        selReg <= hostWdata[HI_W +: SEL_W];
      end
      if (hostStb.wrByte) bitmap[selReg][hostIdx] <= hostWdata;
      if (hostStb.rdIdxLo) hostRdata <= idxLo;
      if (hostStb.rdIdxHi) hostRdata <= hiView;
      if (hostStb.rdByte)  hostRdata <= bitmap[selReg][hostIdx];
      if (hostStb.rdOther) hostRdata <= '0;
    end
  end

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_look
    assign lookByte[s] = bitmap[s][lookIdx[s]];
  end
endmodule

// File: rtl/ts_pidf_rx_ctrl.sv
module ts_pidf_rx_ctrl
  import ts_pidf_pkg::*;
#(
  parameter int PKT_LEN = 188
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inStart,
  input  logic [7:0]       inData,
  input  logic [7:0]       lookByte,
  output logic [IDX_W-1:0] lookIdx,
  output rx_stb_t          stb
);
  localparam int CNT_W = $clog2(PKT_LEN + 1);
  localparam int HDR_W = PID_W - 8;

  logic             inPkt;
  logic             undecided;
  logic             syncOk;
  logic [CNT_W-1:0] cnt;
  logic [HDR_W-1:0] hdrHi;
  logic [PID_W-1:0] pid;
  logic             lowPid;
  logic             atByte2;

  assign pid     = {hdrHi, inData};
  assign lookIdx = pid[PID_W-1:3];
  assign lowPid  = (pid[PID_W-1:LOW_BITS] == '0);
  assign atByte2 = inValid && !inStart && inPkt && (cnt == CNT_W'(2));

  always_comb begin
    stb         = '0;
    stb.push    = inValid && (inStart || inPkt);
    stb.first   = inValid && inStart;
    stb.decPush = (inValid && inStart && undecided) || atByte2;
    stb.decPass = atByte2 && syncOk && (lowPid || !lookByte[inData[2:0]]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPkt     <= 1'b0;
      undecided <= 1'b0;
      syncOk    <= 1'b0;
      cnt       <= '0;
      hdrHi     <= '0;
    end else if (inValid) begin
      if (inStart) begin
        inPkt     <= 1'b1;
        undecided <= 1'b1;
        syncOk    <= (inData == SYNC_BYTE);
        cnt       <= CNT_W'(1);
      end else if (inPkt) begin
        if (cnt == CNT_W'(1)) hdrHi <= inData[HDR_W-1:0];
        if (cnt == CNT_W'(2)) undecided <= 1'b0;
        if (cnt == CNT_W'(PKT_LEN - 1)) inPkt <= 1'b0;
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ts_pidf_tx_path.sv
module ts_pidf_tx_path
  import ts_pidf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  rx_stb_t    stb,
  input  logic [7:0] inData,
  output logic       outValid,
  output logic       outStart,
  output logic [7:0] outData
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [8:0]     fifo [DEPTH];
  logic           decQ [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, decWr, decRd;
  logic [PTR_W:0]   count, decCnt;
  logic           txPass;
  logic           headStart;
  logic [7:0]     headData;
  logic           canPop;
  logic           decPop;
  logic           emitPass;

  assign headStart = fifo[rdPtr][8];
  assign headData  = fifo[rdPtr][7:0];
  assign canPop    = (count != '0) && (!headStart || (decCnt != '0));
  assign decPop    = canPop && headStart;
  assign emitPass  = headStart ? decQ[decRd] : txPass;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        fifo[i] <= '0;
        decQ[i] <= 1'b0;
      end
      wrPtr    <= '0;
      rdPtr    <= '0;
      decWr    <= '0;
      decRd    <= '0;
      count    <= '0;
      decCnt   <= '0;
      txPass   <= 1'b0;
      outValid <= 1'b0;
      outStart <= 1'b0;
      outData  <= '0;
    end else begin
      if (stb.push) begin
        fifo[wrPtr] <= {stb.first, inData};
        wrPtr       <= wrPtr + PTR_W'(1);
      end
      if (canPop) rdPtr <= rdPtr + PTR_W'(1);
      unique case ({stb.push, canPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (stb.decPush) begin
        decQ[decWr] <= stb.decPass;
        decWr       <= decWr + PTR_W'(1);
      end
      if (decPop) begin
        decRd  <= decRd + PTR_W'(1);
        txPass <= decQ[decRd];
      end
      unique case ({stb.decPush, decPop})
        2'b10:   decCnt <= decCnt + 1'b1;
        2'b01:   decCnt <= decCnt - 1'b1;
        default: decCnt <= decCnt;
      endcase
      outValid <= canPop && emitPass;
      outStart <= canPop && emitPass && headStart;
      if (canPop) outData <= headData;
    end
  end
endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
  import ts_pidf_pkg::*;
#(
  parameter int NUM_STREAMS = 2,
  parameter int PKT_LEN     = 188,
  parameter int FIFO_DEPTH  = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hostSel,
  input  logic                        hostWr,
  input  logic [3:0]                  hostAddr,
  input  logic [7:0]                  hostWdata,
  output logic [7:0]                  hostRdata,
  input  logic [NUM_STREAMS-1:0]      inValid,
  input  logic [NUM_STREAMS-1:0]      inStart,
  input  logic [NUM_STREAMS-1:0][7:0] inData,
  output logic [NUM_STREAMS-1:0]      outValid,
  output logic [NUM_STREAMS-1:0]      outStart,
  output logic [NUM_STREAMS-1:0][7:0] outData
);
  host_stb_t                         hostStb;
  rx_stb_t [NUM_STREAMS-1:0]         rxStb;
  logic [NUM_STREAMS-1:0][IDX_W-1:0] lookIdx;
  logic [NUM_STREAMS-1:0][7:0]       lookByte;

  ts_pidf_host_decode u_decode (
    .hostSel (hostSel),
    .hostWr  (hostWr),
    .hostAddr(hostAddr),
    .stb     (hostStb)
  );

  ts_pidf_bitmap_store #(.NUM_STREAMS(NUM_STREAMS)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .hostStb  (hostStb),
    .hostWdata(hostWdata),
    .hostRdata(hostRdata),
    .lookIdx  (lookIdx),
    .lookByte (lookByte)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    ts_pidf_rx_ctrl #(.PKT_LEN(PKT_LEN)) u_rx (
      .clk     (clk),
      .rstN    (rstN),
      .inValid (inValid[s]),
      .inStart (inStart[s]),
      .inData  (inData[s]),
      .lookByte(lookByte[s]),
      .lookIdx (lookIdx[s]),
      .stb     (rxStb[s])
    );
    ts_pidf_tx_path #(.DEPTH(FIFO_DEPTH)) u_tx (
      .clk     (clk),
      .rstN    (rstN),
      .stb     (rxStb[s]),
      .inData  (inData[s]),
      .outValid(outValid[s]),
      .outStart(outStart[s]),
      .outData (outData[s])
    );
  end
endmodule

// File: rtl/ts_pid_filter_chk.sv
module ts_pid_filter_chk
  import ts_pidf_pkg::*;
#(
  parameter int NUM_STREAMS = 2,
  parameter int PKT_LEN     = 188
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        hostSel,
  input logic                        hostWr,
  input logic [3:0]                  hostAddr,
  input logic [7:0]                  hostWdata,
  input logic [7:0]                  hostRdata,
  input logic [NUM_STREAMS-1:0]      inValid,
  input logic [NUM_STREAMS-1:0]      inStart,
  input logic [NUM_STREAMS-1:0][7:0] inData,
  input logic [NUM_STREAMS-1:0]      outValid,
  input logic [NUM_STREAMS-1:0]      outStart,
  input rx_stb_t [NUM_STREAMS-1:0]   rxStb
);
  localparam int CNT_W = $clog2(PKT_LEN + 1);

  // R1: index register written, then read back on the next cycle
  p_idx_readback_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(hostSel && !hostWr && hostAddr == REG_IDX_LO) &&
     $past(hostSel && hostWr && hostAddr == REG_IDX_LO, 2))
    |-> hostRdata == $past(hostWdata, 2));

  // R2: bitmap byte written, then read back at the same index
  p_byte_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(hostSel && !hostWr && hostAddr == REG_BYTE) &&
     $past(hostSel && hostWr && hostAddr == REG_BYTE, 2))
    |-> hostRdata == $past(hostWdata, 2));

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_chk
    logic             mIn;
    logic             mSync;
    logic [CNT_W-1:0] mCnt;
    logic [4:0]       mHdr;
    logic [CNT_W-1:0] oCnt;
    logic             byte2;
    logic             lowId;

    assign byte2 = inValid[s] && !inStart[s] && mIn && (mCnt == CNT_W'(2));
    assign lowId = (mHdr == 5'd0) && (inData[s][7:5] == 3'd0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mIn   <= 1'b0;
        mSync <= 1'b0;
        mCnt  <= '0;
        mHdr  <= '0;
        oCnt  <= '0;
      end else begin
        if (inValid[s] && inStart[s]) begin
          mIn   <= 1'b1;
          mSync <= (inData[s] == SYNC_BYTE);
          mCnt  <= CNT_W'(1);
        end else if (inValid[s] && mIn) begin
          if (mCnt == CNT_W'(1)) mHdr <= inData[s][4:0];
          if (mCnt == CNT_W'(PKT_LEN - 1)) mIn <= 1'b0;
          mCnt <= mCnt + CNT_W'(1);
        end
        if (outValid[s]) oCnt <= outStart[s] ? CNT_W'(1) : oCnt + CNT_W'(1);
      end
    end

    p_low_pid_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
      (byte2 && mSync && lowId) |-> (rxStb[s].decPush && rxStb[s].decPass));

    p_bad_sync_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
      (byte2 && !mSync) |-> (rxStb[s].decPush && !rxStb[s].decPass));

    p_runt_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
      (inValid[s] && inStart[s] && mIn && mCnt < CNT_W'(3))
      |-> (rxStb[s].decPush && !rxStb[s].decPass));

    p_stray_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
      (inValid[s] && !inStart[s] && !mIn) |-> !rxStb[s].push);

    p_start_taken_r7: assert property (@(posedge clk) disable iff (!rstN)
      (inValid[s] && inStart[s]) |-> (rxStb[s].push && rxStb[s].first));

    p_no_orphan_r7: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[s] && !outStart[s]) |-> (oCnt != '0 && oCnt < CNT_W'(PKT_LEN)));
  end
endmodule

bind ts_pid_filter ts_pid_filter_chk #(
  .NUM_STREAMS(NUM_STREAMS),
  .PKT_LEN    (PKT_LEN)
) u_chk (.*);

// File: tb/test_ts_pid_filter.sv
module test_ts_pid_filter;
  import ts_pidf_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 2;
  localparam int PL = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSel = 1'b0, hostWr = 1'b0;
  logic [3:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic [NS-1:0] inValid = '0, inStart = '0;
  logic [NS-1:0][7:0] inData = '0;
  logic [NS-1:0] outValid, outStart;
  logic [NS-1:0][7:0] outData;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_pid_filter #(.NUM_STREAMS(NS), .PKT_LEN(PL), .FIFO_DEPTH(4)) i_ts_pid_filter (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .inValid(inValid), .inStart(inStart),
    .inData(inData), .outValid(outValid), .outStart(outStart), .outData(outData)
  );

  int total = 0;
  int bad = 0;
  string curReq = "R3";
  logic [7:0] shadow [NS][1024];
  logic [8:0] expQ [NS][2048];
  int expWr [NS];
  int expRd [NS];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // output scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      for (int s = 0; s < NS; s++) begin
        if (outValid[s]) begin
          if (expRd[s] >= expWr[s]) begin
            check(1'b0, curReq, {outStart[s], outData[s]}, 'h1ff);
          end else begin
            check({outStart[s], outData[s]} == expQ[s][expRd[s]], curReq,
                  {outStart[s], outData[s]}, expQ[s][expRd[s]]);
            expRd[s]++;
          end
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [7:0] pktByte(input int pid, input int k);
    if (k == 0) return SYNC_BYTE;
    if (k == 1) return {3'b000, 5'(pid >> 8)};
    if (k == 2) return 8'(pid);
    return 8'(k * 7 + pid);
  endfunction

  task automatic hostWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = a;
    @(negedge clk);
    hostSel = 1'b0;
    d = hostRdata;
  endtask

  task automatic setIdx(input int s, input int idx);
    hostWrite(REG_IDX_LO, 8'(idx));
    hostWrite(REG_IDX_HI, 8'((s << 2) | (idx >> 8)));
  endtask

  task automatic bmWrite(input int s, input int idx, input logic [7:0] v);
    setIdx(s, idx);
    hostWrite(REG_BYTE, v);
    shadow[s][idx] = v;
  endtask

  // predict: -1 computes from the shadow bitmap, 0 forces drop, 1 forces pass
  task automatic sendPkt(input int s, input int pid, input logic [7:0] sy,
                         input int len, input int predict);
    bit pass;
    logic [7:0] b;
    if (predict >= 0) pass = (predict != 0);
    else pass = (sy == SYNC_BYTE) && (len >= 3) &&
                ((pid < 32) || !shadow[s][pid >> 3][pid & 7]);
    for (int k = 0; k < len; k++) begin
      b = (k == 0) ? sy : pktByte(pid, k);
      @(negedge clk);
      inValid[s] = 1'b1; inStart[s] = (k == 0); inData[s] = b;
      if (pass) begin
        expQ[s][expWr[s]] = {k == 0, b};
        expWr[s]++;
      end
    end
    @(negedge clk);
    inValid[s] = 1'b0; inStart[s] = 1'b0;
  endtask

  task automatic sendStray(input int s, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid[s] = 1'b1; inStart[s] = 1'b0; inData[s] = 8'(8'h30 + k);
    end
    @(negedge clk);
    inValid[s] = 1'b0;
  endtask

  task automatic drain(input string req);
    repeat (20) @(negedge clk);
    for (int s = 0; s < NS; s++)
      check(expRd[s] == expWr[s], req, expRd[s], expWr[s]);
  endtask

  logic [7:0] rd;

  initial begin
    for (int s = 0; s < NS; s++) begin
      expWr[s] = 0; expRd[s] = 0;
      for (int i = 0; i < 1024; i++) shadow[s][i] = '0;
    end
    repeat (3) @(negedge clk);
    check(outValid == '0, "R3", outValid, 0);
    rstN = 1'b1;

    // R3: cleared bitmaps after reset
    curReq = "R3";
    setIdx(0, 0);     hostRead(REG_BYTE, rd); check(rd == 8'h00, "R3", rd, 0);
    setIdx(1, 1023);  hostRead(REG_BYTE, rd); check(rd == 8'h00, "R3", rd, 0);
    check(outValid == '0, "R3", outValid, 0);

    // R1: index register readback
    hostWrite(REG_IDX_LO, 8'hA5);
    hostWrite(REG_IDX_HI, 8'hFE);
    hostRead(REG_IDX_LO, rd); check(rd == 8'hA5, "R1", rd, 8'hA5);
    hostRead(REG_IDX_HI, rd); check(rd == 8'h06, "R1", rd, 8'h06);
    // R2: unused address reads zero
    hostRead(4'h3, rd); check(rd == 8'h00, "R2", rd, 0);

    // R2 and R6: byte write and readback, other stream untouched
    bmWrite(0, 'h2C5, 8'h96);
    hostRead(REG_BYTE, rd); check(rd == 8'h96, "R2", rd, 8'h96);
    setIdx(1, 'h2C5); hostRead(REG_BYTE, rd); check(rd == 8'h00, "R6", rd, 0);

    // R3: default pass on both streams
    curReq = "R3";
    for (int p = 0; p < 4; p++)
      fork
        sendPkt(0, 'h100 + p, SYNC_BYTE, PL, -1);
        sendPkt(1, 'h900 + p, SYNC_BYTE, PL, -1);
      join
    drain("R3");

    // R4, R5, R6: sweep over identifiers 0..71
    for (int i = 0; i < 8; i++) bmWrite(0, i, 8'hFF);
    bmWrite(0, 8, 8'h5A);
    curReq = "R4";
    for (int p = 0; p < 72; p++)
      fork
        sendPkt(0, p, SYNC_BYTE, PL, -1);
        sendPkt(1, p, SYNC_BYTE, PL, -1);
      join
    drain("R5");

    // R4 and R6: top of the identifier space
    bmWrite(1, 1023, 8'h80);
    curReq = "R4";
    sendPkt(1, 'h1FFF, SYNC_BYTE, PL, -1);
    sendPkt(1, 'h1FFE, SYNC_BYTE, PL, -1);
    sendPkt(0, 'h1FFF, SYNC_BYTE, PL, -1);
    drain("R6");

    // R8: bad sync byte
    curReq = "R8";
    sendPkt(0, 'h100, 8'h46, PL, -1);
    sendPkt(0, 'h101, SYNC_BYTE, PL, -1);
    drain("R8");

    // R9: runts, stray bytes, truncated packet
    curReq = "R9";
    sendPkt(0, 'h110, SYNC_BYTE, 2, -1);
    sendPkt(0, 'h111, SYNC_BYTE, 1, -1);
    sendPkt(0, 'h112, SYNC_BYTE, PL, -1);
    sendStray(0, 5);
    sendPkt(0, 'h113, SYNC_BYTE, 6, -1);
    sendPkt(0, 'h114, SYNC_BYTE, PL, -1);
    drain("R9");

    // R10: write timing relative to the third header byte
    curReq = "R10";
    setIdx(0, 'h40);
    fork
      sendPkt(0, 'h200, SYNC_BYTE, PL, 1);
      begin repeat (2) @(negedge clk); hostWrite(REG_BYTE, 8'h01); end
    join
    shadow[0]['h40] = 8'h01;
    sendPkt(0, 'h200, SYNC_BYTE, PL, -1);
    fork
      sendPkt(0, 'h200, SYNC_BYTE, PL, 1);
      begin repeat (1) @(negedge clk); hostWrite(REG_BYTE, 8'h00); end
    join
    fork
      sendPkt(0, 'h200, SYNC_BYTE, PL, 0);
      begin repeat (1) @(negedge clk); hostWrite(REG_BYTE, 8'h01); end
    join
    fork
      sendPkt(0, 'h200, SYNC_BYTE, PL, 0);
      begin repeat (3) @(negedge clk); hostWrite(REG_BYTE, 8'h00); end
    join
    shadow[0]['h40] = 8'h00;
    sendPkt(0, 'h200, SYNC_BYTE, PL, -1);
    drain("R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule